// File: doc/BRIEF.md
# Eight-Master System Bus Arbiter

This block decides which of eight bus masters may drive a shared system bus. Masters raise bits in a request vector, and the arbiter answers with a one-hot grant. Master 0 is an external bus master with overriding priority. Masters 1 to 6 are on-chip DMA engines: a network address translation engine, two general DMA channels, two Ethernet MAC DMA channels and a USB host. Master 7 is the processor core. Once a grant is given, it stays in place until the owner reports that its transfer is done or drops its request. The grant register then empties for one cycle, and arbitration runs again.

A three-bit configuration port selects the arbitration scheme. In fixed mode the master index is the rank, and index 0 ranks highest. In that mode an interrupt-priority feature can move the core up to second place while an interrupt is being serviced. In rotating mode the external master still wins at once, and the other seven take turns through a round-robin pointer.

Top module: `bus_arbiter`

## Requirements
- R1: After reset, `grant` is all zeros, `bus_busy` is 0 and `cfg_rdata` reads 3'b000 (fixed mode, feature disabled, flag clear).
- R2: `grant` is never more than one-hot. It stays all zeros while no master requests, and a grant only goes to a master that requested on the edge the grant was taken.
- R3: Fixed mode (`cfg_rdata[0]`=0) with the feature inactive: the lowest-numbered requesting master wins, with bit 0 of `req` the highest rank and bit 7 the lowest.
- R4: A grant holds, whatever the other requests do, until its owner asserts `xfer_done` or drops its request. The next edge clears `grant`, and the edge after that issues the next grant if requests are pending.
- R5: Whenever master 0 requests while the bus is free, it is granted next, in either mode.
- R6: Rotating mode (`cfg_rdata[0]`=1): masters 1 to 7 are served round-robin. The search starts at the master after the last one granted, and 7 wraps to 1. A grant to master 0 leaves the pointer unchanged, and after reset the search starts at master 1.
- R7: The priority-active flag (`cfg_rdata[2]`) sets on a rising edge of `irq` only when the enable bit (`cfg_rdata[1]`) is 1 and the arbiter is in fixed mode. In any other case the edge is ignored.
- R8: A write with `cfg_wdata[2]`=0 clears the active flag. A write with `cfg_wdata[2]`=1 leaves the flag unchanged. `cfg_wdata[0]` loads the mode bit and `cfg_wdata[1]` loads the enable bit.
- R9: In fixed mode with both the enable bit and the active flag set, master 7 ranks directly below master 0 and above masters 1 to 6. Masters 1 to 6 keep their relative order.
- R10: In rotating mode the enable bit and the active flag have no effect on which master is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 8 | Request vector; bit i is master i |
| xfer_done | input | 1 | The current owner finishes its transfer |
| irq | input | 1 | Interrupt input; a rising edge can set the active flag |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Write data: bit0 mode, bit1 enable, bit2 flag (0 clears it) |
| cfg_rdata | output | 3 | Read data: bit0 mode, bit1 enable, bit2 active flag |
| grant | output | 8 | One-hot grant vector |
| bus_busy | output | 1 | A grant is currently held |

## Verification
Two situations are hard to reach from the ports. The first is showing that master 0 does not move the round-robin pointer. The second is showing that an active flag set earlier in fixed mode has no effect once the arbiter is in rotating mode.

For the first, the stimulus runs all seven shared masters through a complete rotation. It then lets master 0 take one grant and shows that the rotation resumes at the expected master. For the second, the flag is set by an interrupt edge in fixed mode. The mode is then switched with a write that keeps the flag (flag bit written as 1), and the pointer is placed so that round-robin and core promotion would pick different masters.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic {
      ARB_FIXED  = 1'b0,
      ARB_ROTATE = 1'b1
   } arb_mode_e;

   localparam int CFG_W       = 3;
   localparam int CFG_MODE_B  = 0;
   localparam int CFG_EN_B    = 1;
   localparam int CFG_ACT_B   = 2;
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
   import arb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   input  logic             irq,
   output arb_mode_e        mode,
   output logic             prio_en,
   output logic             prio_act
);
   logic irq_q;
   logic irq_rise;

   assign irq_rise = irq & ~irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q    <= 1'b0;
         mode     <= ARB_FIXED;
         prio_en  <= 1'b0;
         prio_act <= 1'b0;
      end else begin
         irq_q <= irq;
         if (we) begin
            mode    <= arb_mode_e'(wdata[CFG_MODE_B]);
            prio_en <= wdata[CFG_EN_B];
         end
         // a hardware set wins over a clearing write in the same cycle
         if (prio_en && (mode == ARB_FIXED) && irq_rise)
            prio_act <= 1'b1;
         else if (we && !wdata[CFG_ACT_B])
            prio_act <= 1'b0;
      end
   end
endmodule

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
   parameter int N_MASTERS = 8,
   parameter int CORE_IDX  = N_MASTERS - 1,
   localparam int IW       = $clog2(N_MASTERS)
) (
   input  logic [N_MASTERS-1:0] req,
   input  logic                 promote,
   output logic                 win_vld,
   output logic [IW-1:0]        win_idx
);
   always_comb begin
      win_idx = '0;
      for (int i = N_MASTERS - 1; i >= 0; i--) begin
         if (req[i]) win_idx = IW'(i);
      end
      if (promote && req[CORE_IDX] && !req[0])
         win_idx = IW'(CORE_IDX);
      win_vld = |req;
   end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
   parameter int N_MASTERS = 8,
   localparam int IW       = $clog2(N_MASTERS),
   localparam int SHARED   = N_MASTERS - 1
) (
   input  logic [N_MASTERS-1:0] req,
   input  logic [IW-1:0]        ptr,
   output logic                 win_vld,
   output logic [IW-1:0]        win_idx
);
   always_comb begin
      int cand;
      win_idx = '0;
      // descending offset so the smallest offset from the pointer wins
      for (int o = SHARED - 1; o >= 0; o--) begin
         cand = 1 + ((int'(ptr) - 1 + o) % SHARED);
         if (req[cand]) win_idx = IW'(cand);
      end
      if (req[0]) win_idx = '0;
      win_vld = |req;
   end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
   import arb_pkg::*;
#(
   parameter int N_MASTERS = 8,
   parameter int CORE_IDX  = N_MASTERS - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req,
   input  logic                 xfer_done,
   input  logic                 irq,
   input  logic                 cfg_we,
   input  logic [CFG_W-1:0]     cfg_wdata,
   output logic [CFG_W-1:0]     cfg_rdata,
   output logic [N_MASTERS-1:0] grant,
   output logic                 bus_busy
);
   localparam int          IW       = $clog2(N_MASTERS);
   localparam logic [IW-1:0] LAST_IDX = IW'(N_MASTERS - 1);
   localparam logic [IW-1:0] FIRST_RR = IW'(1);

   generate
      if (N_MASTERS < 3) begin : g_bad_count
         $error("bus_arbiter: N_MASTERS must be at least 3");
      end
      if (CORE_IDX < 1 || CORE_IDX >= N_MASTERS) begin : g_bad_core
         $error("bus_arbiter: CORE_IDX out of range");
      end
   endgenerate

   arb_mode_e     mode;
   logic          prio_en, prio_act, promote;
   logic          fx_vld, rr_vld, sel_vld;
   logic [IW-1:0] fx_idx, rr_idx, sel_idx;
   logic          gnt_vld;
   logic [IW-1:0] gnt_idx;
   logic [IW-1:0] rr_ptr;
   logic          release_now;

   arb_cfg_regs u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .wdata    (cfg_wdata),
      .irq      (irq),
      .mode     (mode),
      .prio_en  (prio_en),
      .prio_act (prio_act)
   );

   assign promote = (mode == ARB_FIXED) && prio_en && prio_act;

   arb_fixed_pick #(.N_MASTERS(N_MASTERS), .CORE_IDX(CORE_IDX)) u_fixed (
      .req     (req),
      .promote (promote),
      .win_vld (fx_vld),
      .win_idx (fx_idx)
   );

   arb_rr_pick #(.N_MASTERS(N_MASTERS)) u_rr (
      .req     (req),
      .ptr     (rr_ptr),
      .win_vld (rr_vld),
      .win_idx (rr_idx)
   );

   assign sel_vld     = (mode == ARB_ROTATE) ? rr_vld : fx_vld;
   assign sel_idx     = (mode == ARB_ROTATE) ? rr_idx : fx_idx;
   assign release_now = gnt_vld && (xfer_done || !req[gnt_idx]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_vld <= 1'b0;
         gnt_idx <= '0;
         rr_ptr  <= FIRST_RR;
      end else if (gnt_vld) begin
         if (release_now) gnt_vld <= 1'b0;
      end else if (sel_vld) begin
         gnt_vld <= 1'b1;
         gnt_idx <= sel_idx;
         if (mode == ARB_ROTATE && sel_idx != '0)
            rr_ptr <= (sel_idx == LAST_IDX) ? FIRST_RR : sel_idx + FIRST_RR;
      end
   end

   generate
      for (genvar g = 0; g < N_MASTERS; g++) begin : g_grant
         assign grant[g] = gnt_vld && (gnt_idx == IW'(g));
      end
   endgenerate

   assign bus_busy = gnt_vld;
   assign cfg_rdata[CFG_MODE_B] = mode;
   assign cfg_rdata[CFG_EN_B]   = prio_en;
   assign cfg_rdata[CFG_ACT_B]  = prio_act;
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
   parameter int N_MASTERS = 8,
   parameter int CORE_IDX  = N_MASTERS - 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_MASTERS-1:0] req,
   input logic                 xfer_done,
   input logic                 cfg_we,
   input logic [2:0]           cfg_wdata,
   input logic [2:0]           cfg_rdata,
   input logic [N_MASTERS-1:0] grant
);
   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0) |=> ((grant & $past(req)) == grant));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant != '0) && !xfer_done && ((req & grant) != '0)) |=> $stable(grant));

   assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant != '0) && (xfer_done || ((req & grant) == '0))) |=> (grant == '0));

   assert_ext_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant == '0) && req[0]) |=> grant[0]);

   assert_flag_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[2] && cfg_rdata[2]) |=> cfg_rdata[2]);

   assert_core_promote_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant == '0) && !cfg_rdata[0] && cfg_rdata[1] && cfg_rdata[2]
       && req[CORE_IDX] && !req[0]) |=> grant[CORE_IDX]);
endmodule

bind bus_arbiter bus_arbiter_chk #(.N_MASTERS(N_MASTERS), .CORE_IDX(CORE_IDX)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req),
   .xfer_done (xfer_done),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .grant     (grant)
);

// File: tb/sim_bus_arbiter.sv
`timescale 1ns/1ps
module sim_bus_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req = '0;
   logic       xfer_done = 1'b0;
   logic       irq = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_wdata = '0;
   logic [2:0] cfg_rdata;
   logic [7:0] grant;
   logic       bus_busy;
   int         checks = 0;
   int         errors = 0;

   always #2 clk = ~clk;

   bus_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done), .irq(irq),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .grant(grant), .bus_busy(bus_busy)
   );

   // {promote, req, expected grant}: fixed-mode vectors
   localparam int NV = 14;
   localparam logic [16:0] VEC [NV] = '{
      {1'b0, 8'hFF, 8'h01}, {1'b0, 8'hFE, 8'h02}, {1'b0, 8'hFC, 8'h04},
      {1'b0, 8'hF8, 8'h08}, {1'b0, 8'hF0, 8'h10}, {1'b0, 8'hE0, 8'h20},
      {1'b0, 8'hC0, 8'h40}, {1'b0, 8'h80, 8'h80}, {1'b0, 8'h90, 8'h10},
      {1'b0, 8'h81, 8'h01}, {1'b1, 8'h81, 8'h01}, {1'b1, 8'h82, 8'h80},
      {1'b1, 8'hFE, 8'h80}, {1'b1, 8'h7E, 8'h02}
   };

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic irq_pulse();
      @(negedge clk); irq = 1'b1;
      @(negedge clk); irq = 1'b0;
   endtask

   // requests already driven, grant register empty, at a falling edge
   task automatic take_grant(input logic [7:0] exp, input string tag);
      @(posedge clk); @(negedge clk);
      chk(grant, exp, tag);
      xfer_done = 1'b1;
      @(posedge clk); @(negedge clk);
      xfer_done = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; req = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      chk(grant, 8'h00, "R1 grant after reset");
      chk({7'b0, bus_busy}, 8'h00, "R1 busy after reset");
      chk({5'b0, cfg_rdata}, 8'h00, "R1 config after reset");

      // R2: idle bus stays idle
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(grant, 8'h00, "R2 no request");
      end

      // R3 / R9 table walk
      for (int v = 0; v < NV; v++) begin
         cfg_write({1'b0, VEC[v][16], 1'b0});
         if (VEC[v][16]) irq_pulse();
         @(negedge clk); req = VEC[v][15:8];
         @(posedge clk); @(negedge clk);
         chk(grant, VEC[v][7:0], VEC[v][16] ? "R9 promoted order" : "R3 fixed order");
         xfer_done = 1'b1; req = '0;
         @(posedge clk); @(negedge clk);
         xfer_done = 1'b0;
         chk(grant, 8'h00, "R4 released after done");
      end

      // R4 hold against a higher-ranked arrival
      cfg_write(3'b000);
      @(negedge clk); req = 8'h06;
      @(posedge clk); @(negedge clk);
      chk(grant, 8'h02, "R4 first grant");
      req = 8'h07;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(grant, 8'h02, "R4 grant held");
      end
      xfer_done = 1'b1;
      @(posedge clk); @(negedge clk);
      xfer_done = 1'b0;
      chk(grant, 8'h00, "R4 idle cycle");
      @(posedge clk); @(negedge clk);
      chk(grant, 8'h01, "R4 regrant after idle");
      xfer_done = 1'b1; req = '0;
      @(posedge clk); @(negedge clk);
      xfer_done = 1'b0;

      // R6 rotation from reset
      do_reset();
      cfg_write(3'b001);
      @(negedge clk); req = 8'hFE;
      take_grant(8'h02, "R6 rotate 1");
      take_grant(8'h04, "R6 rotate 2");
      take_grant(8'h08, "R6 rotate 3");
      take_grant(8'h10, "R6 rotate 4");
      take_grant(8'h20, "R6 rotate 5");
      take_grant(8'h40, "R6 rotate 6");
      take_grant(8'h80, "R6 rotate 7");
      take_grant(8'h02, "R6 wrap to 1");
      req = 8'hFF;
      take_grant(8'h01, "R5 external wins in rotate");
      req = 8'hFE;
      take_grant(8'h04, "R6 pointer kept over external");

      // R4 release by request withdrawal
      req = 8'h20;
      @(posedge clk); @(negedge clk);
      chk(grant, 8'h20, "R6 skip idle masters");
      req = 8'h00;
      @(posedge clk); @(negedge clk);
      chk(grant, 8'h00, "R4 released on withdrawal");

      // R10: flag set in fixed mode, kept across switch to rotating
      cfg_write(3'b010);
      irq_pulse();
      chk({5'b0, cfg_rdata}, 8'h06, "R7 flag set in fixed mode");
      cfg_write(3'b111);
      chk({5'b0, cfg_rdata}, 8'h07, "R8 write one keeps flag");
      @(negedge clk); req = 8'h80;
      take_grant(8'h80, "R6 core in rotation");
      req = 8'h82;
      take_grant(8'h02, "R10 flag ignored in rotate");
      req = 8'h00;

      // R7 edge ignored cases
      cfg_write(3'b011);
      irq_pulse();
      chk({5'b0, cfg_rdata}, 8'h03, "R7 no set in rotate");
      cfg_write(3'b000);
      irq_pulse();
      chk({5'b0, cfg_rdata}, 8'h00, "R7 no set when disabled");
      cfg_write(3'b010);
      irq_pulse();
      chk({5'b0, cfg_rdata}, 8'h06, "R7 set when enabled");

      // R8 clear rules
      cfg_write(3'b110);
      chk({5'b0, cfg_rdata}, 8'h06, "R8 write one no effect");
      cfg_write(3'b010);
      chk({5'b0, cfg_rdata}, 8'h02, "R8 write zero clears");
      cfg_write(3'b110);
      chk({5'b0, cfg_rdata}, 8'h02, "R8 write one does not set");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule